// File: doc/BRIEF.md
# Serial audio data transmitter

This block sends a stereo pair of two's-complement samples, 24 bits each, over one serial data line. The shift timing follows a bit clock and a word clock. Both clocks come either from a divider inside the block (master) or from an outside master (slave). In slave mode the outside clocks are brought into the system clock domain by a synchronizer. The falling edges of the bit clock are detected there.

Two framings are supported, chosen by a format input. In left-justified framing a high word clock marks the left channel, and the MSB occupies the first bit slot of the half-frame. In I2S framing a low word clock marks the left channel, and the MSB comes one bit slot after the word clock edge. Both framings share one shift register. The register fills with zeros as it shifts, so any slot beyond the last data bit is sent low. Under I2S, a bit that did not fit into the previous half-frame goes out in the first slot of the next one.

A half-frame may carry 24 or more slots. It may also carry exactly 16 slots (a 32fs frame), in which case only the upper 16 bits of each sample are sent. Power-down clears the block and holds every output low.

Top module: `sdtx_serializer`

## Requirements
- R1: Each channel word goes out MSB first as the SAMPLE_W-bit two's-complement sample. Every slot after the LSB, up to the next word clock change, carries 0.
- R2: The serial data output changes only as a result of a bit clock falling edge, or of power-down. It is therefore stable across each bit clock rising edge.
- R3: With fmt_i2s = 0, word clock high selects the left sample and word clock low the right one. Sample bit SAMPLE_W-1 is sent in slot 0, the slot that begins with the falling edge on which the word clock changed.
- R4: With fmt_i2s = 1, word clock low selects the left sample and word clock high the right one. Sample bit SAMPLE_W-1 is sent in slot 1. Slot 0 carries the next unsent bit of the previous half-frame's sample, or 0 when that sample was sent completely.
- R5: In a half-frame of 16 slots (32fs), bits SAMPLE_W-1 down to SAMPLE_W-16 are sent. Under fmt_i2s = 1, bit SAMPLE_W-16 is sent in slot 0 of the following half-frame.
- R6: Both left_in and right_in are captured at the start of each left half-frame. The right half-frame that follows sends the captured right value, even if right_in changes meanwhile.
- R7: The slot position returns to 0 on every word clock change, so half-frames of any length of 24 slots or more, and of 16 slots, may be mixed.
- R8: While pwr_dn is 1, sdto, sclk_out and lrck_out are 0 from the next clock on and all state is cleared. After release, sdto stays 0 until the first word clock change that follows at least one bit clock falling edge.
- R9: With master_en = 1, sclk_out has a period of 2*HALF_DIV clocks. lrck_out toggles only together with a falling edge of sclk_out, once every SLOTS_PER_HALF bit clock periods, starting low after release.
- R10: With master_en = 0, sclk_out and lrck_out are 0, and data timing follows sclk_in and lrck_in after SYNC_STAGES clocks of synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: clears state and holds outputs low |
| master_en | input | 1 | 1: generate bit and word clocks locally; 0: follow outside clocks |
| fmt_i2s | input | 1 | 0: left-justified framing; 1: I2S framing |
| sclk_in | input | 1 | Bit clock from an outside master |
| lrck_in | input | 1 | Word clock from an outside master |
| left_in | input | SAMPLE_W | Left channel sample |
| right_in | input | SAMPLE_W | Right channel sample |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated word clock (master mode) |
| sdto | output | 1 | Serial data output |

## Verification
A shift register that loses or gains a position shows up as wrong bits at the port in the very next slot. A misdetected word clock change shows up too, because the MSB then lands in the wrong slot or the I2S carry bit goes missing. That is visible within one half-frame. A capture taken at the wrong moment surfaces only in the right half-frame that follows, and only if right_in has changed meanwhile. For this reason the stimulus changes both inputs in the middle of right half-frames. Half-frame lengths are drawn at random and mixed with 16- and 24-slot frames. Any counter that assumes a fixed frame length therefore produces misplaced bits in the first frame of a different length.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;

   typedef enum logic {
      FMT_LEFT_JUST = 1'b0,
      FMT_I2S       = 1'b1
   } sdtx_fmt_e;

   // Word clock level that selects the left channel depends on framing.
   function automatic logic chan_is_left(sdtx_fmt_e fmt, logic lr);
      return (fmt == FMT_I2S) ? !lr : lr;
   endfunction

endpackage

// File: rtl/sdtx_sync.sv
module sdtx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ff <= 1'b0;
            else if (clr) ff <= 1'b0;
            else          ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   chain <= '0;
            else if (clr) chain <= '0;
            else          chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sdtx_fall_det.sv
module sdtx_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lvl,
   output logic fall
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= 1'b0;
      else if (clr) lvl_q <= 1'b0;
      else          lvl_q <= lvl;
   end

   assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/sdtx_clkgen.sv
module sdtx_clkgen #(
   parameter int HALF_DIV       = 4,
   parameter int SLOTS_PER_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic sclk_o,
   output logic lrck_o,
   output logic fall_o
);
   localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int SW = (SLOTS_PER_HALF > 1) ? $clog2(SLOTS_PER_HALF) : 1;
   localparam logic [DW-1:0] DIV_LAST  = DW'(HALF_DIV - 1);
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS_PER_HALF - 1);

   logic [DW-1:0] div_q;
   logic [SW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= '0;
         sclk_o <= 1'b0;
         lrck_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (!enable) begin
         div_q  <= '0;
         slot_q <= '0;
         sclk_o <= 1'b0;
         lrck_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (div_q == DIV_LAST) begin
         div_q  <= '0;
         sclk_o <= ~sclk_o;
         fall_o <= sclk_o;
         if (sclk_o) begin
            if (slot_q == SLOT_LAST) begin
               slot_q <= '0;
               lrck_o <= ~lrck_o;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end else begin
         div_q  <= div_q + 1'b1;
         fall_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sdtx_shifter.sv
module sdtx_shifter
   import sdtx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                fall,
   input  logic                lrck,
   input  sdtx_fmt_e           fmt,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                sdto
);
   logic                seen_q;
   logic                lr_prev_q;
   logic [SAMPLE_W-1:0] hold_r_q;
   logic [SAMPLE_W-1:0] sreg_q;
   logic                lr_change;
   logic                is_left;
   logic [SAMPLE_W-1:0] next_word;

   assign lr_change = fall & seen_q & (lrck != lr_prev_q);
   assign is_left   = chan_is_left(fmt, lrck);
   assign next_word = is_left ? left_in : hold_r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         lr_prev_q <= 1'b0;
         hold_r_q  <= '0;
         sreg_q    <= '0;
         sdto      <= 1'b0;
      end else if (clr) begin
         seen_q    <= 1'b0;
         lr_prev_q <= 1'b0;
         hold_r_q  <= '0;
         sreg_q    <= '0;
         sdto      <= 1'b0;
      end else if (fall) begin
         seen_q    <= 1'b1;
         lr_prev_q <= lrck;
         if (lr_change) begin
            if (is_left) hold_r_q <= right_in;
            if (fmt == FMT_I2S) begin
               sdto   <= sreg_q[SAMPLE_W-1];
               sreg_q <= next_word;
            end else begin
               sdto   <= next_word[SAMPLE_W-1];
               sreg_q <= {next_word[SAMPLE_W-2:0], 1'b0};
            end
         end else begin
            sdto   <= sreg_q[SAMPLE_W-1];
            sreg_q <= {sreg_q[SAMPLE_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/sdtx_serializer.sv
module sdtx_serializer
   import sdtx_pkg::*;
#(
   parameter int SAMPLE_W       = 24,
   parameter int HALF_DIV       = 4,
   parameter int SLOTS_PER_HALF = 32,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_dn,
   input  logic                master_en,
   input  logic                fmt_i2s,
   input  logic                sclk_in,
   input  logic                lrck_in,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                sclk_out,
   output logic                lrck_out,
   output logic                sdto
);
   generate
      if (SAMPLE_W < 16) begin : g_bad_width
         $error("SAMPLE_W must be at least 16");
      end
      if (HALF_DIV < 2) begin : g_bad_div
         $error("HALF_DIV must be at least 2");
      end
      if (SLOTS_PER_HALF < SAMPLE_W) begin : g_bad_slots
         $error("SLOTS_PER_HALF must hold a full sample");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   sdtx_fmt_e fmt_sel;
   logic      gen_en;
   logic      gen_sclk, gen_lrck, gen_fall;
   logic      sclk_s, lrck_s, slv_fall;
   logic      fall_sel, lr_sel;

   assign fmt_sel = sdtx_fmt_e'(fmt_i2s);
   assign gen_en  = master_en & ~pwr_dn;

   sdtx_clkgen #(
      .HALF_DIV       (HALF_DIV),
      .SLOTS_PER_HALF (SLOTS_PER_HALF)
   ) u_clkgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (gen_en),
      .sclk_o (gen_sclk),
      .lrck_o (gen_lrck),
      .fall_o (gen_fall)
   );

   sdtx_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
      .clk (clk), .rst_n (rst_n), .clr (pwr_dn), .d (sclk_in), .q (sclk_s)
   );

   sdtx_sync #(.STAGES(SYNC_STAGES)) u_sync_lrck (
      .clk (clk), .rst_n (rst_n), .clr (pwr_dn), .d (lrck_in), .q (lrck_s)
   );

   sdtx_fall_det u_fall (
      .clk (clk), .rst_n (rst_n), .clr (pwr_dn), .lvl (sclk_s), .fall (slv_fall)
   );

   assign fall_sel = master_en ? gen_fall : slv_fall;
   assign lr_sel   = master_en ? gen_lrck : lrck_s;

   sdtx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (pwr_dn),
      .fall     (fall_sel),
      .lrck     (lr_sel),
      .fmt      (fmt_sel),
      .left_in  (left_in),
      .right_in (right_in),
      .sdto     (sdto)
   );

   assign sclk_out = gen_sclk;
   assign lrck_out = gen_lrck;
endmodule

// File: rtl/sdtx_serializer_chk.sv
module sdtx_serializer_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_dn,
   input logic master_en,
   input logic sclk_out,
   input logic lrck_out,
   input logic sdto,
   input logic fall_evt
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_SDTO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(fall_evt) && !$past(pwr_dn)) |-> $stable(sdto)); // R2

   AST_SDTO_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && master_en && $past(master_en) && $rose(sclk_out)) |-> $stable(sdto)); // R2

   AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pwr_dn)) |-> (!sdto && !sclk_out && !lrck_out)); // R8

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(master_en)) |-> (!sclk_out && !lrck_out)); // R10

   AST_LR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(master_en) && !$past(pwr_dn) && !$stable(lrck_out))
         |-> $fell(sclk_out)); // R9
endmodule

bind sdtx_serializer sdtx_serializer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_dn    (pwr_dn),
   .master_en (master_en),
   .sclk_out  (sclk_out),
   .lrck_out  (lrck_out),
   .sdto      (sdto),
   .fall_evt  (fall_sel)
);

// File: tb/sdtx_serializer_bench.sv
`timescale 1ns/1ps
module sdtx_serializer_bench;
   localparam int W    = 24;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b1;
   logic master_en = 1'b0;
   logic fmt = 1'b0;
   logic sclk_in = 1'b1;
   logic lrck_in = 1'b0;
   logic [W-1:0] left_in = '0;
   logic [W-1:0] right_in = '0;
   logic sclk_out, lrck_out, sdto;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [W-1:0] m_prev;
   int           m_prevlen;
   logic [W-1:0] m_hold_r;

   always #10 clk = ~clk;

   sdtx_serializer u_sdtx_serializer (
      .clk (clk), .rst_n (rst_n), .pwr_dn (pwr_dn), .master_en (master_en),
      .fmt_i2s (fmt), .sclk_in (sclk_in), .lrck_in (lrck_in),
      .left_in (left_in), .right_in (right_in),
      .sclk_out (sclk_out), .lrck_out (lrck_out), .sdto (sdto)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_bit(logic f, int slot, logic [W-1:0] cur,
                                    logic [W-1:0] prev, int plen);
      if (!f) return (slot < W) ? cur[W-1-slot] : 1'b0;
      if (slot == 0) return (plen >= 1 && plen <= W) ? prev[W-plen] : 1'b0;
      return (slot <= W) ? cur[W-slot] : 1'b0;
   endfunction

   task automatic new_samples();
      left_in  = W'($urandom);
      right_in = W'($urandom);
   endtask

   task automatic power_cycle(input logic f, input logic m);
      @(negedge clk);
      pwr_dn = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         sclk_in = ~sclk_in;
         @(negedge clk);
         chk("R8 pd sdto", {31'd0, sdto}, 32'd0);
         chk("R8 pd clocks", {30'd0, sclk_out, lrck_out}, 32'd0);
      end
      sclk_in   = 1'b1;
      fmt       = f;
      master_en = m;
      repeat (4) @(negedge clk);
      pwr_dn    = 1'b0;
      m_prev    = '0;
      m_prevlen = 0;
      m_hold_r  = '0;
      repeat (2) @(negedge clk);
   endtask

   // One half-frame of outside clocks; pre marks the segment before any edge.
   task automatic slave_half(input logic lvl, input int n, input bit pre,
                             input bit chg, input string tag);
      logic         is_l;
      logic [W-1:0] cur;
      is_l = fmt ? !lvl : lvl;
      if (pre) cur = '0;
      else if (is_l) begin
         cur      = left_in;
         m_hold_r = right_in;
      end else cur = m_hold_r;
      for (int s = 0; s < n; s++) begin
         @(negedge clk);
         sclk_in = 1'b0;
         if (s == 0) lrck_in = lvl;
         repeat (6) @(negedge clk);
         if (pre) chk({tag, " pre-edge zero R8"}, {31'd0, sdto}, 32'd0);
         else chk(tag, {31'd0, sdto}, {31'd0, exp_bit(fmt, s, cur, m_prev, m_prevlen)});
         if (s == 0) chk("R10 slave quiet", {30'd0, sclk_out, lrck_out}, 32'd0);
         if (chg && !pre && !is_l && s == n/2) new_samples();
         sclk_in = 1'b1;
         repeat (5) @(negedge clk);
      end
      m_prev    = cur;
      m_prevlen = n;
   endtask

   task automatic slave_frame(input int nl, input int nr, input bit chg, input string tag);
      logic lv;
      lv = fmt ? 1'b0 : 1'b1;
      slave_half(lv, nl, 1'b0, chg, tag);
      slave_half(~lv, nr, 1'b0, chg, tag);
   endtask

   task automatic master_run(input logic f, input int halves, input string tag);
      logic         prev_sc, last_lr, is_l;
      logic [W-1:0] cur;
      int           slot, gap, edges;
      bit           started, first_rise;
      prev_sc = 1'b0; last_lr = 1'b0; is_l = 1'b0; cur = '0;
      slot = 0; gap = 0; edges = 0; started = 0; first_rise = 1;
      for (int cyc = 0; cyc < 40000 && edges <= halves; cyc++) begin
         @(negedge clk);
         gap++;
         if (sclk_out && !prev_sc) begin
            if (!first_rise) chk("R9 bit clock period", gap, 2*HALF);
            first_rise = 0;
            gap = 0;
            if (lrck_out != last_lr) begin
               if (started) begin
                  chk("R9 slots per half", slot, 32);
                  m_prev    = cur;
                  m_prevlen = slot;
               end
               last_lr = lrck_out;
               started = 1;
               edges++;
               is_l = f ? !lrck_out : lrck_out;
               if (is_l) begin
                  cur      = left_in;
                  m_hold_r = right_in;
               end else cur = m_hold_r;
               slot = 0;
            end
            if (started)
               chk(tag, {31'd0, sdto}, {31'd0, exp_bit(f, slot, cur, m_prev, m_prevlen)});
            else
               chk("R8 master pre-edge zero", {31'd0, sdto}, 32'd0);
            if (started && !is_l && slot == 10) new_samples();
            slot++;
         end
         prev_sc = sclk_out;
      end
      chk("R9 word clock edges seen", {31'd0, edges > halves}, 32'd1);
   endtask

   initial begin
      void'($urandom(32'h5D7A_0C41));
      m_prev = '0; m_prevlen = 0; m_hold_r = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pwr_dn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 reset sdto", {31'd0, sdto}, 32'd0);
      chk("R10 reset clocks", {30'd0, sclk_out, lrck_out}, 32'd0);

      // Left-justified, 64fs, corner samples then random.
      power_cycle(1'b0, 1'b0);
      slave_half(1'b0, 5, 1'b1, 1'b0, "R3");
      left_in = 24'h800000; right_in = 24'h7FFFFF;
      slave_frame(32, 32, 1'b0, "R3 R1 corner");
      left_in = 24'hFFFFFF; right_in = 24'h000001;
      slave_frame(32, 32, 1'b0, "R1 corner");
      for (int k = 0; k < 3; k++) begin
         new_samples();
         slave_frame(32, 32, 1'b1, "R6 R3");
      end
      // 48fs and random lengths
      new_samples();
      slave_frame(24, 24, 1'b1, "R1 48fs");
      for (int k = 0; k < 5; k++) begin
         slave_frame(24 + int'($urandom_range(0, 16)), 24 + int'($urandom_range(0, 16)),
                     1'b1, "R7 R6");
      end
      // 32fs, then power-down while data is live
      slave_frame(16, 16, 1'b1, "R5 lj");
      slave_frame(16, 16, 1'b1, "R5 lj");

      // I2S framing
      power_cycle(1'b1, 1'b0);
      slave_half(1'b1, 5, 1'b1, 1'b0, "R4");
      left_in = 24'h800001; right_in = 24'h7FFFFE;
      slave_frame(32, 32, 1'b0, "R4 corner");
      for (int k = 0; k < 2; k++) slave_frame(32, 32, 1'b1, "R4 R6");
      slave_frame(24, 24, 1'b1, "R4 48fs carry");
      for (int k = 0; k < 3; k++) slave_frame(16, 16, 1'b1, "R5 i2s carry");
      for (int k = 0; k < 4; k++) begin
         slave_frame(24 + int'($urandom_range(0, 16)), 16 + 8*int'($urandom_range(0, 1)),
                     1'b1, "R7 i2s");
      end

      // Master mode, both framings
      power_cycle(1'b0, 1'b1);
      new_samples();
      master_run(1'b0, 8, "R9 R3 master");
      power_cycle(1'b1, 1'b1);
      new_samples();
      master_run(1'b1, 8, "R9 R4 master");

      // Back to slave after master: generated clocks quiet
      power_cycle(1'b0, 1'b0);
      slave_half(1'b0, 3, 1'b1, 1'b0, "R10");
      new_samples();
      slave_frame(32, 32, 1'b0, "R10 R3 after master");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule